// File: doc/BRIEF.md
# Parallel EEPROM Host Controller

This block sits between a synchronous request port and an asynchronous byte-wide EEPROM bus. The bus has a 13-bit address, an 8-bit data path and three active-low strobes: chip select, output enable and write strobe. A requester offers one single-byte read or write through a valid/ready handshake. The controller turns each request into a strobe sequence on the bus. Every timing window is a whole number of clock cycles, so address setup, read access time and write pulse width are met by counting.

A read lowers chip select and output enable together for the access window. At the end of that window it captures the returned byte and raises a one-cycle done pulse. A write drives the data for the whole write-strobe window, then releases the bus. It then stays busy for a hold interval plus the memory's self-timed programming period, which defaults to 5 ms at 200 MHz. The data driver is enabled only while the write strobe is low. It is therefore always off before output enable can fall.

Top module: `eeprom_host_ctrl`

## Requirements
- R1: While reset is asserted and on release: chip select, output enable and write strobe are high, `ee_dq_oe` is low, `busy` is low, `req_ready` is high and `rd_done` is low.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. From the next cycle `busy` is high. From that cycle `ee_addr` shows the accepted address and keeps it until the next acceptance.
- R3: After acceptance, all three strobes stay high for exactly SETUP_CYC cycles before chip select falls.
- R4: A read (`req_write`=0) holds chip select and output enable low, with the write strobe high, for exactly ACC_CYC cycles.
- R5: The edge that ends the read access window captures `ee_dq_in` into `rd_data`. In the following cycle `rd_done` is high for exactly one cycle, chip select and output enable are high again, and `busy` is low.
- R6: A write (`req_write`=1) holds chip select and the write strobe low, with output enable high, for exactly PULSE_CYC cycles. During that window `ee_dq_out` equals the accepted write byte.
- R7: `ee_dq_oe` is high exactly during the write-strobe-low window. It is never high while output enable is low, and it is low in the cycle before output enable falls.
- R8: After the write strobe rises, all strobes stay high and `busy` stays high for HOLD_CYC + PROG_CYC cycles. Then `busy` falls.
- R9: `req_valid` while `busy` is high is ignored. `ee_addr` does not change, and a request dropped before `busy` falls never starts a cycle.
- R10: `req_ready` is the inverse of `busy`. A request held valid while a read finishes is accepted at the edge where `rd_done` is high, so the next cycle starts with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rd_data | output | 8 | Byte returned by the last read |
| rd_done | output | 1 | One-cycle pulse: `rd_data` is valid |
| busy | output | 1 | Access or programming period in progress |
| ee_addr | output | 13 | EEPROM address bus |
| ee_ce_n | output | 1 | Chip select, active low |
| ee_oe_n | output | 1 | Output enable, active low |
| ee_we_n | output | 1 | Write strobe, active low |
| ee_dq_out | output | 8 | Data driven toward the EEPROM |
| ee_dq_oe | output | 1 | Tristate enable for `ee_dq_out` |
| ee_dq_in | input | 8 | Data read from the EEPROM bus |

## Verification
The end of a read and the acceptance of the next request can fall in the same cycle. The `rd_done` pulse and the return of `req_ready` coincide, so a requester holding `req_valid` high is accepted on that very edge. The bench provokes this by issuing read after read, and write after read, without ever lowering `req_valid`. A behavioural schedule model predicts every output on every cycle. Each collision is judged by the captured byte being the old address's content and by the new address and setup phase appearing in the next cycle.

// File: rtl/eeprom_ctrl_pkg.sv
package eeprom_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_SETUP    = 3'd1,
        ST_RD_ACC   = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4,
        ST_WR_WAIT  = 3'd5
    } ctrl_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/eeprom_down_timer.sv
module eeprom_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/eeprom_strobe_fsm.sv
module eeprom_strobe_fsm
    import eeprom_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int PH_W      = 5,
    parameter int WT_W      = 20,
    parameter int SETUP_CYC = 1,
    parameter int ACC_CYC   = 24,
    parameter int PULSE_CYC = 20,
    parameter int HOLD_CYC  = 1,
    parameter int PROG_CYC  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              phase_zero,
    input  logic              wait_zero,
    output logic              phase_load,
    output logic [PH_W-1:0]   phase_val,
    output logic              wait_load,
    output logic [WT_W-1:0]   wait_val,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rd_done_o,
    output logic              ce_n_o,
    output logic              oe_n_o,
    output logic              we_n_o,
    output logic              dq_oe_o,
    output logic              busy_o
);

    typedef struct packed {
        ctrl_state_e       state;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rd_done;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              busy;
    } regs_t;

    localparam logic [PH_W-1:0] SETUP_LD = PH_W'(SETUP_CYC - 1);
    localparam logic [PH_W-1:0] ACC_LD   = PH_W'(ACC_CYC - 1);
    localparam logic [PH_W-1:0] PULSE_LD = PH_W'(PULSE_CYC - 1);
    localparam logic [PH_W-1:0] HOLD_LD  = PH_W'(HOLD_CYC - 1);
    localparam logic [WT_W-1:0] PROG_LD  = WT_W'(PROG_CYC - 1);

    regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        r_d.rd_done = 1'b0;
        phase_load = 1'b0;
        phase_val  = '0;
        wait_load  = 1'b0;
        wait_val   = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.addr   = req_addr;
                    r_d.wdata  = req_wdata;
                    r_d.write  = req_write;
                    r_d.busy   = 1'b1;
                    r_d.state  = ST_SETUP;
                    phase_load = 1'b1;
                    phase_val  = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (phase_zero) begin
                    r_d.ce_n   = 1'b0;
                    phase_load = 1'b1;
                    if (r_q.write) begin
                        r_d.we_n  = 1'b0;
                        r_d.dq_oe = 1'b1;
                        r_d.state = ST_WR_PULSE;
                        phase_val = PULSE_LD;
                    end else begin
                        r_d.oe_n  = 1'b0;
                        r_d.state = ST_RD_ACC;
                        phase_val = ACC_LD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (phase_zero) begin
                    r_d.rdata   = dq_in;
                    r_d.rd_done = 1'b1;
                    r_d.ce_n    = 1'b1;
                    r_d.oe_n    = 1'b1;
                    r_d.busy    = 1'b0;
                    r_d.state   = ST_IDLE;
                end
            end
            ST_WR_PULSE: begin
                if (phase_zero) begin
                    r_d.ce_n   = 1'b1;
                    r_d.we_n   = 1'b1;
                    r_d.dq_oe  = 1'b0;
                    r_d.state  = ST_WR_HOLD;
                    phase_load = 1'b1;
                    phase_val  = HOLD_LD;
                end
            end
            ST_WR_HOLD: begin
                if (phase_zero) begin
                    r_d.state = ST_WR_WAIT;
                    wait_load = 1'b1;
                    wait_val  = PROG_LD;
                end
            end
            ST_WR_WAIT: begin
                if (wait_zero) begin
                    r_d.busy  = 1'b0;
                    r_d.state = ST_IDLE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.ce_n  = 1'b1;
                r_d.oe_n  = 1'b1;
                r_d.we_n  = 1'b1;
                r_d.dq_oe = 1'b0;
                r_d.busy  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, write: 1'b0, addr: '0, wdata: '0,
                     rdata: '0, rd_done: 1'b0, ce_n: 1'b1, oe_n: 1'b1,
                     we_n: 1'b1, dq_oe: 1'b0, busy: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign addr_o    = r_q.addr;
    assign wdata_o   = r_q.wdata;
    assign rdata_o   = r_q.rdata;
    assign rd_done_o = r_q.rd_done;
    assign ce_n_o    = r_q.ce_n;
    assign oe_n_o    = r_q.oe_n;
    assign we_n_o    = r_q.we_n;
    assign dq_oe_o   = r_q.dq_oe;
    assign busy_o    = r_q.busy;

endmodule

// File: rtl/eeprom_host_ctrl.sv
module eeprom_host_ctrl
    import eeprom_ctrl_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 1,        // address stable before strobes fall, >= 1
    parameter int ACC_CYC   = 24,       // 120 ns at 200 MHz
    parameter int PULSE_CYC = 20,       // write strobe width, 100 ns at 200 MHz
    parameter int HOLD_CYC  = 1,        // address hold after write strobe rises
    parameter int PROG_CYC  = 1000000   // 5 ms self-timed programming at 200 MHz
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done,
    output logic              busy,
    output logic [ADDR_W-1:0] ee_addr,
    output logic              ee_ce_n,
    output logic              ee_oe_n,
    output logic              ee_we_n,
    output logic [DATA_W-1:0] ee_dq_out,
    output logic              ee_dq_oe,
    input  logic [DATA_W-1:0] ee_dq_in
);

    localparam int PH_MAX = max2(max2(SETUP_CYC, ACC_CYC), max2(PULSE_CYC, HOLD_CYC));
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam int WT_W   = $clog2(PROG_CYC + 1);

    logic            start;
    logic            phase_load, phase_zero;
    logic [PH_W-1:0] phase_val;
    logic            wait_load, wait_zero;
    logic [WT_W-1:0] wait_val;

    assign req_ready = ~busy;
    assign start     = req_valid & ~busy;

    eeprom_down_timer #(.W(PH_W)) u_phase_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (phase_load),
        .load_val (phase_val),
        .zero     (phase_zero)
    );

    eeprom_down_timer #(.W(WT_W)) u_prog_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .zero     (wait_zero)
    );

    eeprom_strobe_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .PH_W      (PH_W),
        .WT_W      (WT_W),
        .SETUP_CYC (SETUP_CYC),
        .ACC_CYC   (ACC_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .dq_in      (ee_dq_in),
        .phase_zero (phase_zero),
        .wait_zero  (wait_zero),
        .phase_load (phase_load),
        .phase_val  (phase_val),
        .wait_load  (wait_load),
        .wait_val   (wait_val),
        .addr_o     (ee_addr),
        .wdata_o    (ee_dq_out),
        .rdata_o    (rd_data),
        .rd_done_o  (rd_done),
        .ce_n_o     (ee_ce_n),
        .oe_n_o     (ee_oe_n),
        .we_n_o     (ee_we_n),
        .dq_oe_o    (ee_dq_oe),
        .busy_o     (busy)
    );

endmodule

// File: rtl/eeprom_host_ctrl_chk.sv
module eeprom_host_ctrl_chk #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 1,
    parameter int PROG_CYC = 1000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              rd_done,
    input logic [ADDR_W-1:0] ee_addr,
    input logic              ee_ce_n,
    input logic              ee_oe_n,
    input logic              ee_we_n,
    input logic [DATA_W-1:0] ee_dq_out,
    input logic              ee_dq_oe
);

    logic [31:0] since_we;
    logic        wrote;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_we <= '0;
            wrote    <= 1'b0;
        end else begin
            if (!ee_we_n) begin
                since_we <= '0;
            end else if (since_we != '1) begin
                since_we <= since_we + 1'b1;
            end
            if (!ee_we_n) begin
                wrote <= 1'b1;
            end else if (!busy) begin
                wrote <= 1'b0;
            end
        end
    end

    a_r3_addr_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_ce_n) |-> $stable(ee_addr) && $past(busy));

    a_r2_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_ce_n && $past(!ee_ce_n)) |-> $stable(ee_addr));

    a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_oe_n |-> (!ee_ce_n && ee_we_n));

    a_r6_write_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_we_n |-> (!ee_ce_n && ee_oe_n && ee_dq_oe));

    a_r6_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!ee_we_n && $past(!ee_we_n)) |-> $stable(ee_dq_out));

    a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
        ee_dq_oe |-> ee_oe_n);

    a_r7_release_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_oe_n) |-> !$past(ee_dq_oe));

    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |-> (!busy && ee_oe_n && ee_ce_n && $past(!ee_oe_n)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !rd_done);

    a_r8_prog_wait: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && wrote) |-> (since_we == 32'(HOLD_CYC + PROG_CYC)));

    a_r8_quiet_while_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (wrote && ee_we_n && busy) |-> (ee_ce_n && ee_oe_n && !ee_dq_oe));

endmodule

bind eeprom_host_ctrl eeprom_host_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .HOLD_CYC (HOLD_CYC),
    .PROG_CYC (PROG_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .rd_done   (rd_done),
    .ee_addr   (ee_addr),
    .ee_ce_n   (ee_ce_n),
    .ee_oe_n   (ee_oe_n),
    .ee_we_n   (ee_we_n),
    .ee_dq_out (ee_dq_out),
    .ee_dq_oe  (ee_dq_oe)
);

// File: tb/eeprom_host_ctrl_test.sv
`timescale 1ns/1ps
module eeprom_host_ctrl_test;

    localparam int S = 2;
    localparam int A = 5;
    localparam int P = 3;
    localparam int H = 2;
    localparam int W = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_done, busy;
    logic [7:0]  rd_data;
    logic [12:0] ee_addr;
    logic        ee_ce_n, ee_oe_n, ee_we_n, ee_dq_oe;
    logic [7:0]  ee_dq_out;
    logic [7:0]  ee_dq_in = 8'hA5;

    always #2.5 clk = ~clk;

    eeprom_host_ctrl #(
        .SETUP_CYC (S),
        .ACC_CYC   (A),
        .PULSE_CYC (P),
        .HOLD_CYC  (H),
        .PROG_CYC  (W)
    ) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .rd_done   (rd_done),
        .busy      (busy),
        .ee_addr   (ee_addr),
        .ee_ce_n   (ee_ce_n),
        .ee_oe_n   (ee_oe_n),
        .ee_we_n   (ee_we_n),
        .ee_dq_out (ee_dq_out),
        .ee_dq_oe  (ee_dq_oe),
        .ee_dq_in  (ee_dq_in)
    );

    int vectors = 0;
    int fails   = 0;
    bit summary_done = 1'b0;

    // memory device on the bus
    logic [7:0]  dev_mem [8192];
    logic [7:0]  ref_mem [8192];
    logic        dev_we_last = 1'b1;
    logic [12:0] cap_addr = '0;
    logic [7:0]  cap_data = '0;

    initial begin
        for (int i = 0; i < 8192; i++) begin
            dev_mem[i] = 8'(i) ^ 8'h3C;
            ref_mem[i] = 8'(i) ^ 8'h3C;
        end
    end

    always @(negedge clk) begin
        if (!ee_we_n) begin
            cap_addr = ee_addr;
            cap_data = ee_dq_out;
        end else if (!dev_we_last) begin
            dev_mem[cap_addr] = cap_data;
        end
        dev_we_last = ee_we_n;
        if (!ee_ce_n && !ee_oe_n) ee_dq_in = dev_mem[ee_addr];
        else                      ee_dq_in = 8'hA5;
    end

    // schedule model: position of the current access counted in cycles
    bit          m_act = 1'b0;
    bit          m_wr = 1'b0;
    int          m_rel = 0;
    logic [12:0] m_addr = '0;
    logic [7:0]  m_data = '0;
    logic [7:0]  m_rdata = '0;
    bit          m_done = 1'b0;

    always @(posedge clk) begin
        m_done = 1'b0;
        if (!rst_n) begin
            m_act = 1'b0; m_addr = '0; m_rdata = '0; m_rel = 0;
        end else if (m_act) begin
            m_rel++;
            if (m_wr && m_rel == S + P) ref_mem[m_addr] = m_data;
            if (!m_wr && m_rel == S + A) begin
                m_rdata = ref_mem[m_addr];
                m_done  = 1'b1;
                m_act   = 1'b0;
            end
            if (m_wr && m_rel == S + P + H + W) m_act = 1'b0;
        end else if (req_valid) begin
            m_act = 1'b1; m_rel = 0; m_wr = req_write;
            m_addr = req_addr; m_data = req_wdata;
        end
    end

    task automatic chk(input string req, input string what, input int actv, input int expv);
        vectors++;
        if (actv != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, actv, expv, $time);
        end
    endtask

    always @(negedge clk) begin
        bit rd_win, wr_win;
        rd_win = m_act && !m_wr && m_rel >= S && m_rel < S + A;
        wr_win = m_act &&  m_wr && m_rel >= S && m_rel < S + P;
        chk(!rst_n ? "R1" : "R3", "ce_n", int'(ee_ce_n), int'(!(rd_win || wr_win)));
        chk(!rst_n ? "R1" : "R4", "oe_n", int'(ee_oe_n), int'(!rd_win));
        chk(!rst_n ? "R1" : "R6", "we_n", int'(ee_we_n), int'(!wr_win));
        chk(!rst_n ? "R1" : "R7", "dq_oe", int'(ee_dq_oe), int'(wr_win));
        chk(!rst_n ? "R1" : (m_wr ? "R8" : "R2"), "busy", int'(busy), int'(m_act));
        chk(!rst_n ? "R1" : "R10", "req_ready", int'(req_ready), int'(!m_act));
        chk(!rst_n ? "R1" : "R5", "rd_done", int'(rd_done), int'(m_done));
        chk(!rst_n ? "R1" : "R2", "ee_addr", int'(ee_addr), int'(m_addr));
        chk(!rst_n ? "R1" : "R5", "rd_data", int'(rd_data), int'(m_rdata));
        if (wr_win) chk("R6", "dq_out", int'(ee_dq_out), int'(m_data));
    end

    // present a request and wait for its acceptance; req_valid stays high
    task automatic do_req(input bit wr, input logic [12:0] a, input logic [7:0] d);
        bit rdy;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        forever begin
            rdy = req_ready;
            @(negedge clk);
            if (rdy) break;
        end
    endtask

    task automatic idle_until_free();
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!summary_done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // boundary addresses, writes then reads
        do_req(1'b1, 13'h0000, 8'h5A);
        do_req(1'b1, 13'h1FFF, 8'hC3);
        do_req(1'b0, 13'h0000, 8'h00);
        do_req(1'b0, 13'h1FFF, 8'h00);
        do_req(1'b0, 13'h0123, 8'h00);   // R10 collision: read after read
        do_req(1'b1, 13'h0123, 8'h77);   // R10 collision: write after read
        do_req(1'b0, 13'h0123, 8'h00);
        idle_until_free();

        // R9: requests while busy are ignored
        do_req(1'b1, 13'h0AAA, 8'h11);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 13'h0555;
        repeat (3) @(negedge clk);
        req_valid = 1'b0;
        chk("R9", "addr held while busy", int'(ee_addr), int'(13'h0AAA));
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R9", "no late start", int'(busy), 0);
        chk("R9", "addr after idle", int'(ee_addr), int'(13'h0AAA));

        // mixed traffic on a small address set
        lfsr = 16'hACE1;
        for (int i = 0; i < 30; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_req(lfsr[0] & lfsr[5], {lfsr[4] ? 10'h3FF : 10'h000, lfsr[3:1]}, lfsr[15:8]);
            if (lfsr[6]) idle_until_free();
        end
        idle_until_free();
        repeat (4) @(negedge clk);

        summary_done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule